// File: doc/BRIEF.md
# Flash Line Prefetch Read Controller

This block connects a 32-bit processor read port to an embedded flash array that returns one 128-bit line (16 bytes) per access. Two line buffers keep recently read lines. While the processor works through one line, the controller fetches the next sequential line into the other buffer. Straight-line code running from slow flash therefore sees no wait cycles once the first line has been loaded. The flash latency comes from a programmable wait-state count. Every flash access keeps the line index steady for `wait_states + 1` cycles, and the data is captured on the last of those cycles.

The processor side uses a simple handshake. `cpu_req` and its address and size stay steady until `cpu_ready` is high. `cpu_rdata` is valid in that cycle. The flash appears throughout the address window: address bits above the flash size are ignored.

The control path is a state machine with three states:
- **IDLE**: no flash access is running.
- **DEMAND**: fetching a line that the processor asked for and that missed both buffers.
- **PREFETCH**: fetching the line that follows the one just used.

Its transitions are:
- **miss** (any state to DEMAND): the requested line is in neither buffer and is not being fetched. Any fetch in progress is abandoned.
- **lookahead** (IDLE to PREFETCH): a buffer hit occurs and the other buffer does not already hold the next line.
- **follow-on** (DEMAND to PREFETCH, or PREFETCH to PREFETCH): a fetch completes that served, or is serving, the processor, and the next line is not buffered.
- **settle** (to IDLE): any other completion.
- **flush** (any state to IDLE): invalidates both buffers.

Top module: `flash_prefetch_ctrl`

## Requirements
- R1: After reset `cpu_ready` and `fl_en` are low and neither buffer holds a line, so the first read of any line is a miss.
- R2: A read whose line is neither buffered nor being fetched gets `cpu_ready` only after `wait_states + 1` stall cycles.
- R3: During a flash access `fl_en` is high and `fl_line` is steady for `wait_states + 1` cycles. The line data is taken from `fl_rdata` in the last of those cycles.
- R4: `cpu_size` selects the read width: 0 is a byte, 1 is a halfword, 2 or 3 is a word. A byte read returns the byte at `cpu_addr[3:0]`. A halfword read uses `cpu_addr[3:1]` and ignores bit 0. A word read uses `cpu_addr[3:2]` and ignores bits 1 and 0. Narrow results are right-justified and zero-extended. Bytes are little-endian within each 32-bit word, and word k of the line is `fl_rdata[32k+31:32k]`.
- R5: A read of a line held valid in a buffer gets `cpu_ready` in the same cycle, even while the other buffer is being filled.
- R6: When a fetch that served the processor completes, the following line is fetched into the other buffer. A later read of that line, made after it has arrived, has no wait.
- R7: Idle cycles between reads do not discard a buffered or prefetched line.
- R8: A read of the line currently being fetched stalls until the fetch completes. `cpu_ready` then rises in the completion cycle, with data taken directly from `fl_rdata`.
- R9: A miss abandons any fetch in progress, including one that completes in the same cycle. The demand fetch of the requested line starts in the next cycle.
- R10: Line index is `cpu_addr[LINE_IDX_W+3:4]`, and higher address bits are ignored. The line after the last line is line 0.
- R11: A `flush` cycle gives no `cpu_ready`, stops any fetch and invalidates both buffers, so the next read is a miss.
- R12: With `wait_states` = 0 each flash access takes one cycle. A miss stalls one cycle, and a read of a line being prefetched has no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate both buffers and stop any fetch |
| wait_states | input | WS_W | Extra flash cycles per access |
| cpu_req | input | 1 | Read request, held until ready |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_ready | output | 1 | Read completes this cycle |
| cpu_rdata | output | 32 | Right-justified read data |
| fl_en | output | 1 | Flash access in progress |
| fl_line | output | LINE_IDX_W | Line index being read |
| fl_rdata | input | 128 | Flash line data |

## Verification
The risky overlap is a demand miss arriving in the very cycle a lookahead fetch completes. Two events compete here: the buffer write from the completion and the invalidation for the new miss. A directed case places the miss exactly `wait_states` idle cycles after a hit that launched a lookahead. It expects `wait_states + 1` stall cycles, the correct data, and a zero-wait read of the line after the missed one. Random sequences with a fixed seed also make buffer hits coincide with fill completions. Each read is judged on its data and on a stall bound of `wait_states + 1`.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

    localparam int FPB_OFF_W     = 4;
    localparam int FPB_LINE_BITS = 8 << FPB_OFF_W;
    localparam int FPB_WORD_BITS = 32;

    localparam logic [1:0] FPB_SZ_BYTE = 2'd0;
    localparam logic [1:0] FPB_SZ_HALF = 2'd1;

    typedef enum logic [1:0] {
        FPB_IDLE     = 2'd0,
        FPB_DEMAND   = 2'd1,
        FPB_PREFETCH = 2'd2
    } fpb_state_e;

endpackage

// File: rtl/fpb_line_store.sv
module fpb_line_store #(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wr_en,
    input  logic                wr_idx,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                inv_en,
    input  logic                inv_idx,
    input  logic [TAG_W-1:0]    look_tag,
    output logic [1:0]          hit,
    output logic [1:0]          valid,
    output logic [2*TAG_W-1:0]  tags,
    output logic [DATA_W-1:0]   hit_line
);

    logic [DATA_W-1:0] ent_data [2];

    for (genvar e = 0; e < 2; e++) begin : g_ent
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else if (flush) begin
                v_q <= 1'b0;
            end else if (inv_en && inv_idx == 1'(e)) begin
                v_q <= 1'b0;
            end else if (wr_en && wr_idx == 1'(e)) begin
                v_q <= 1'b1;
                t_q <= wr_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == 1'(e)) begin
                d_q <= wr_data;
            end
        end

        assign valid[e]                  = v_q;
        assign tags[e*TAG_W +: TAG_W]    = t_q;
        assign hit[e]                    = v_q && (t_q == look_tag);
        assign ent_data[e]               = d_q;
    end

    assign hit_line = hit[1] ? ent_data[1] : ent_data[0];

    // Two buffers never hold the same valid line (R5)
    assert_single_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // A flush leaves no valid line behind (R11)
    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid == 2'b00));

endmodule

// File: rtl/fpb_lane_select.sv
module fpb_lane_select
    import fpb_pkg::*;
(
    input  logic [FPB_LINE_BITS-1:0] line,
    input  logic [FPB_OFF_W-1:0]     off,
    input  logic [1:0]               size,
    output logic [FPB_WORD_BITS-1:0] data
);

    logic [FPB_WORD_BITS-1:0] word;
    logic [7:0]               byte_v;
    logic [15:0]              half_v;

    always_comb begin
        word   = FPB_WORD_BITS'(line >> {off[3:2], 5'b0});
        byte_v = 8'(word >> {off[1:0], 3'b0});
        half_v = 16'(word >> {off[1], 4'b0});
        unique case (size)
            FPB_SZ_BYTE: data = {24'b0, byte_v};
            FPB_SZ_HALF: data = {16'b0, half_v};
            default:     data = word;
        endcase
    end

endmodule

// File: rtl/flash_prefetch_ctrl.sv
module flash_prefetch_ctrl
    import fpb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_IDX_W = 6,
    parameter int WS_W       = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [WS_W-1:0]          wait_states,
    input  logic                     cpu_req,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [1:0]               cpu_size,
    output logic                     cpu_ready,
    output logic [FPB_WORD_BITS-1:0] cpu_rdata,
    output logic                     fl_en,
    output logic [LINE_IDX_W-1:0]    fl_line,
    input  logic [FPB_LINE_BITS-1:0] fl_rdata
);

    localparam int LW     = LINE_IDX_W;
    localparam int LINE_HI = LW + FPB_OFF_W - 1;

    fpb_state_e          state_q, state_d;
    logic [WS_W-1:0]     cnt_q, cnt_d;
    logic                fill_buf_q, fill_buf_d;
    logic [LW-1:0]       fill_tag_q, fill_tag_d;
    logic                mru_q, mru_d;

    logic [LW-1:0]       req_line, next_tag, hit_next;
    logic [1:0]          ent_hit, ent_valid;
    logic [2*LW-1:0]     ent_tags;
    logic [LW-1:0]       tag0, tag1;
    logic [FPB_LINE_BITS-1:0] hit_line, sel_line;
    logic                hit_any, hit_idx, busy, done, pend_hit, miss;
    logic                other_has_next, hit_other_has;
    logic                wr_en, inv_en, inv_idx;
    logic                unused_hi;

    assign req_line  = cpu_addr[LINE_HI:FPB_OFF_W];
    assign unused_hi = ^cpu_addr[ADDR_W-1:LINE_HI+1];
    assign tag0      = ent_tags[LW-1:0];
    assign tag1      = ent_tags[2*LW-1:LW];
    assign hit_any   = |ent_hit;
    assign hit_idx   = ent_hit[1];
    assign busy      = (state_q != FPB_IDLE);
    assign done      = busy && (cnt_q >= wait_states);
    assign pend_hit  = busy && (fill_tag_q == req_line);
    assign miss      = cpu_req && !hit_any && !pend_hit;
    assign next_tag  = fill_tag_q + 1'b1;
    assign hit_next  = req_line + 1'b1;
    assign other_has_next = ent_valid[~fill_buf_q] &&
                            (((~fill_buf_q) ? tag1 : tag0) == next_tag);
    assign hit_other_has  = ent_valid[~hit_idx] &&
                            (((~hit_idx) ? tag1 : tag0) == hit_next);

    fpb_line_store #(.TAG_W(LW), .DATA_W(FPB_LINE_BITS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_idx   (fill_buf_q),
        .wr_tag   (fill_tag_q),
        .wr_data  (fl_rdata),
        .inv_en   (inv_en),
        .inv_idx  (inv_idx),
        .look_tag (req_line),
        .hit      (ent_hit),
        .valid    (ent_valid),
        .tags     (ent_tags),
        .hit_line (hit_line)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= FPB_IDLE;
            cnt_q      <= '0;
            fill_buf_q <= 1'b0;
            fill_tag_q <= '0;
            mru_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            fill_buf_q <= fill_buf_d;
            fill_tag_q <= fill_tag_d;
            mru_q      <= mru_d;
        end
    end

    // Transitions and buffer control
    always_comb begin
        state_d    = state_q;
        cnt_d      = busy ? cnt_q + 1'b1 : '0;
        fill_buf_d = fill_buf_q;
        fill_tag_d = fill_tag_q;
        mru_d      = mru_q;
        wr_en      = done && !flush;
        inv_en     = 1'b0;
        inv_idx    = 1'b0;
        if (flush) begin
            state_d = FPB_IDLE;
            cnt_d   = '0;
        end else if (miss) begin
            state_d    = FPB_DEMAND;
            cnt_d      = '0;
            fill_buf_d = ~mru_q;
            fill_tag_d = req_line;
            mru_d      = ~mru_q;
            inv_en     = 1'b1;
            inv_idx    = ~mru_q;
        end else if (done) begin
            cnt_d   = '0;
            state_d = FPB_IDLE;
            if (cpu_req && pend_hit) mru_d = fill_buf_q;
            unique case (state_q)
                FPB_DEMAND, FPB_PREFETCH: begin
                    if ((state_q == FPB_DEMAND || (cpu_req && pend_hit)) && !other_has_next) begin
                        state_d    = FPB_PREFETCH;
                        fill_buf_d = ~fill_buf_q;
                        fill_tag_d = next_tag;
                        inv_en     = 1'b1;
                        inv_idx    = ~fill_buf_q;
                    end
                end
                default: state_d = FPB_IDLE;
            endcase
        end else if (cpu_req && hit_any) begin
            mru_d = hit_idx;
            if (!busy && !hit_other_has) begin
                state_d    = FPB_PREFETCH;
                cnt_d      = '0;
                fill_buf_d = ~hit_idx;
                fill_tag_d = hit_next;
                inv_en     = 1'b1;
                inv_idx    = ~hit_idx;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            FPB_DEMAND, FPB_PREFETCH: fl_en = 1'b1;
            default:                  fl_en = 1'b0;
        endcase
        fl_line   = fill_tag_q;
        cpu_ready = cpu_req && !flush && (hit_any || (pend_hit && done));
        sel_line  = hit_any ? hit_line : fl_rdata;
    end

    fpb_lane_select u_lane (
        .line (sel_line),
        .off  (cpu_addr[FPB_OFF_W-1:0]),
        .size (cpu_size),
        .data (cpu_rdata)
    );

    // An access keeps its line until it completes or is abandoned (R3)
    assert_line_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !done && !flush && !miss) |=> (fl_en && $stable(fl_line)));

    // The wait counter never passes the programmed count (R2)
    assert_wait_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && $past(fl_en) && $stable(wait_states)) |-> (cnt_q <= wait_states));

    // A miss starts the demand fetch of its own line next cycle (R9)
    assert_miss_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !flush) |=> (fl_en && fl_line == $past(req_line)));

    // A finished demand fetch is followed by the next line (R6)
    assert_follow_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state_q == FPB_DEMAND && !flush && !miss && !other_has_next)
        |=> (fl_en && fl_line == $past(next_tag)));

endmodule

// File: tb/tb_flash_prefetch_ctrl.sv
module tb_flash_prefetch_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic [3:0]   ws = 4'd2;
    logic         req = 1'b0;
    logic [31:0]  addr = '0;
    logic [1:0]   size = 2'd2;
    logic         ready;
    logic [31:0]  rdata;
    logic         fl_en;
    logic [LW-1:0] fl_line;
    logic [127:0] fl_rdata;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prefetch_ctrl #(.ADDR_W(32), .LINE_IDX_W(LW), .WS_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wait_states(ws),
        .cpu_req(req), .cpu_addr(addr), .cpu_size(size),
        .cpu_ready(ready), .cpu_rdata(rdata),
        .fl_en(fl_en), .fl_line(fl_line), .fl_rdata(fl_rdata)
    );

    function automatic logic [31:0] mk_word(input int line, input int k);
        return 32'(32'h9E3779B1 * (line * 4 + k + 1));
    endfunction

    function automatic logic [127:0] mk_line(input int line);
        logic [127:0] l;
        for (int k = 0; k < 4; k++) l[32*k +: 32] = mk_word(line, k);
        return l;
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] w;
        w = mk_word(int'(a[9:4]), int'(a[3:2]));
        case (sz)
            2'd0:    return (w >> (8 * a[1:0])) & 32'hFF;
            2'd1:    return (w >> (16 * a[1])) & 32'hFFFF;
            default: return w;
        endcase
    endfunction

    // Flash model: line data appears only on the wait_states+1-th steady cycle (R3)
    logic         prev_en = 1'b0, prev_done = 1'b0;
    logic [LW-1:0] prev_line = '0;
    int           prev_age = 0, cur_age;
    logic         fdone;
    always_comb begin
        cur_age  = (prev_en && !prev_done && fl_line == prev_line) ? prev_age + 1 : 0;
        fdone    = fl_en && (cur_age == int'(ws));
        fl_rdata = fdone ? mk_line(int'(fl_line)) : {4{32'hDEADBEEF}};
    end
    always @(posedge clk) begin
        prev_en   <= fl_en;
        prev_line <= fl_line;
        prev_age  <= cur_age;
        prev_done <= fdone;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [31:0] a, input logic [1:0] sz,
                           output logic [31:0] d, output int waits);
        @(negedge clk);
        req = 1'b1; addr = a; size = sz; waits = 0;
        #1;
        while (!ready && waits <= 64) begin
            @(negedge clk); #1;
            waits++;
        end
        d = rdata;
        @(posedge clk); #1;
        req = 1'b0;
    endtask

    // exp_waits < 0: only the stall bound is checked
    task automatic rd_chk(input logic [31:0] a, input logic [1:0] sz,
                          input int exp_waits, input string rq);
        logic [31:0] d;
        int w;
        do_read(a, sz, d, w);
        check(d === exp_data(a, sz), rq, "data", d, exp_data(a, sz));
        if (exp_waits >= 0)
            check(w == exp_waits, rq, "waits", 32'(w), 32'(exp_waits));
        else
            check(w <= int'(ws) + 1, rq, "wait bound", 32'(w), 32'(int'(ws) + 1));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int W;
        logic [31:0] a_prev;
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check(ready == 1'b0, "R1", "ready after reset", 32'(ready), 32'd0);
        check(fl_en == 1'b0, "R1", "fl_en after reset", 32'(fl_en), 32'd0);
        W = int'(ws);

        // R1/R2: first read is a full miss
        rd_chk(32'h0000_0100, 2'd2, W + 1, "R2");
        // R6/R7: next line already prefetched, idle gap does not lose it
        idle(W + 5);
        rd_chk(32'h0000_0110, 2'd2, 0, "R7");
        // R8: read of line being prefetched stalls until completion
        rd_chk(32'h0000_0120, 2'd2, W, "R8");
        // R9: miss aborts the follow-on prefetch
        rd_chk(32'h0000_0280, 2'd2, W + 1, "R9");
        idle(2 * W + 4);
        rd_chk(32'h0000_0130, 2'd2, W + 1, "R9");
        // R4/R5: lane selection on the buffered line, no wait during refill of other
        rd_chk(32'h0000_0130, 2'd0, 0, "R4");
        rd_chk(32'h0000_0131, 2'd0, 0, "R4");
        rd_chk(32'h0000_0132, 2'd0, 0, "R4");
        rd_chk(32'h0000_013F, 2'd0, 0, "R4");
        rd_chk(32'h0000_0134, 2'd1, 0, "R4");
        rd_chk(32'h0000_0136, 2'd1, 0, "R4");
        rd_chk(32'h0000_0137, 2'd1, 0, "R4");
        rd_chk(32'h0000_013B, 2'd2, 0, "R4");
        rd_chk(32'h0000_013D, 2'd3, 0, "R5");
        // Miss coinciding with a prefetch completion
        idle(2 * W + 4);
        rd_chk(32'h0000_0140, 2'd2, 0, "R6");
        idle(W);
        rd_chk(32'h0000_0320, 2'd2, W + 1, "R9");
        idle(2 * W + 4);
        rd_chk(32'h0000_0330, 2'd2, 0, "R6");
        // R10: aliasing and wrap of the prefetch to line 0
        idle(2 * W + 4);
        rd_chk(32'hABCD_03F0, 2'd2, W + 1, "R10");
        idle(2 * W + 4);
        rd_chk(32'h0000_0004, 2'd2, 0, "R10");
        rd_chk(32'h7000_0008, 2'd2, 0, "R10");
        // R11: flush cycle gives no ready and empties the buffers
        idle(2 * W + 4);
        @(negedge clk);
        flush = 1'b1; req = 1'b1; addr = 32'h0000_0004; size = 2'd2;
        #1;
        check(ready == 1'b0, "R11", "ready in flush cycle", 32'(ready), 32'd0);
        @(posedge clk); #1;
        flush = 1'b0; req = 1'b0;
        rd_chk(32'h0000_0004, 2'd2, W + 1, "R11");
        // R12: zero wait states
        idle(2 * W + 4);
        ws = 4'd0; W = 0;
        idle(2);
        rd_chk(32'h0000_01E0, 2'd2, 1, "R12");
        idle(3);
        rd_chk(32'h0000_01F0, 2'd2, 0, "R12");
        rd_chk(32'h0000_0200, 2'd2, 0, "R12");
        // R3: flash data only on the final access cycle; random mix
        for (int blk = 0; blk < 2; blk++) begin
            idle(40);
            ws = (blk == 0) ? 4'd1 : 4'd3;
            idle(4);
            a_prev = 32'h0000_0000;
            for (int i = 0; i < 150; i++) begin
                logic [31:0] a;
                if (($urandom % 10) < 7) a = a_prev + 32'd4;
                else a = $urandom;
                a_prev = a;
                rd_chk(a, 2'($urandom % 4), -1, "R3");
                if (($urandom % 4) == 0) idle(int'($urandom % 4));
            end
        end
        finish_run();
    end

endmodule